// File: doc/BRIEF.md
# Dual phase-shifter rotation controller

This block turns a stream of phase advance and retard requests into an unbounded phase slew. It does this by steering two clock phase-shift units, each of which saturates at the ends of a 0 to 255 step range. One unit is active and its output clock is chosen by an external glitch-free mux through the select bit. The other unit is standby and waits at the end of its range opposite to the slew direction. When the active unit cannot move further, the select flips, the standby unit takes over from its end of range, and the two units trade roles. Seen through the select, the phase moves one step per request, modulo the range, with no limit in either direction.

Each phase-shift unit receives a one-cycle step pulse with a direction bit and answers with a step-done acknowledge. Requests that arrive while a unit is still acknowledging, or still inside its minimum step spacing, are held as a signed pending count. In the default mode the standby unit is driven to its parked end after each hand-off. A build-time mirror variant instead steps the standby unit against the active one on every step, so that the two positions always sum to the range maximum and no re-parking is needed.

Top module: `phase_slew_ctrl`

## Requirements
- R1: After reset, unit A is active at position 128 and `sel_o` is 0. Unit B is at 0, or at 127 in mirror mode. No step pulse and no overrun are present.
- R2: When `adv_i` and `ret_i` are high in the same cycle, nothing is counted. Each counted request moves `phase_o` by exactly one step in its own direction, modulo 256, and by at most one step per cycle.
- R3: The pending count is signed and saturates at +15 and -15. A request that would take it past that bound is dropped.
- R4: `sel_o` toggles only when a step is due and the active unit sits at the limit in that direction: 255 when advancing, 0 when retarding. The toggle uses up one pending step. The newly active unit is then at 0 (advancing) or at 255 (retarding).
- R5: In default mode the standby unit walks to its parked end: 0 while the slew direction is advance, 255 while it is retard. Here the slew direction is the sign of the pending count, or the last nonzero sign when the count is empty. A reversal during the walk retargets the unit to the other end.
- R6: In default mode, if a hand-off is due but the standby unit is not yet at its parked end, or is still waiting for its acknowledge, the hand-off is held and `overrun_o` is high. `sel_o` never changes in a cycle that follows an overrun cycle.
- R7: In mirror mode the standby unit steps in the opposite direction on every active step. As a result `pos_a_o + pos_b_o` is always 255, and `overrun_o` stays low.
- R8: A unit receives no new step pulse until it has acknowledged its previous one.
- R9: Two step pulses to the same unit are at least `MIN_GAP` cycles apart. The default is 100.
- R10: A unit's position output changes only in the cycle its step pulse is high. It changes by exactly one, upward when the direction bit is 1 and downward when it is 0, and it never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Phase advance request, one per high cycle |
| ret_i | input | 1 | Phase retard request, one per high cycle |
| ack_a_i | input | 1 | Step-done acknowledge from unit A |
| ack_b_i | input | 1 | Step-done acknowledge from unit B |
| step_a_o | output | 1 | Step pulse to unit A |
| dir_a_o | output | 1 | Direction for unit A, 1 = up |
| step_b_o | output | 1 | Step pulse to unit B |
| dir_b_o | output | 1 | Direction for unit B, 1 = up |
| sel_o | output | 1 | Clock mux select, 0 = unit A drives |
| pos_a_o | output | POS_W | Position of unit A |
| pos_b_o | output | POS_W | Position of unit B |
| phase_o | output | POS_W | Position of the unit currently selected |
| overrun_o | output | 1 | Hand-off held because the standby unit is not parked |

## Verification
The hardest case to reach from the ports is a held hand-off. It needs the active unit to arrive at its limit while the standby unit is still walking toward its parked end. A long advance run can never produce it, because both units cover the same distance at the same rate. The stimulus gets there by retarding straight out of reset: the active unit needs only 128 steps to reach 0, while unit B must climb all 255 steps to its new parked end. The same runs then reverse direction, which exercises retargeting of a standby unit that is partway through its walk. A held burst of advances drives the pending count into saturation.

// File: rtl/phs_pkg.sv
`timescale 1ns/1ps
package phs_pkg;
  // command to one phase-shift unit
  typedef struct packed {
    logic go;
    logic up;
  } step_cmd_t;
endpackage

// File: rtl/phs_step_timer.sv
`timescale 1ns/1ps
module phs_step_timer #(
  parameter int MIN_GAP = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic ack_i,
  output logic busy_o,
  output logic ready_o
);
  localparam int GW = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP + 1);

  logic [GW-1:0] gap_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      busy_q <= 1'b0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      gap_q  <= GW'(MIN_GAP - 1);
    end else begin
      if (ack_i) busy_q <= 1'b0;
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = !busy_q && (gap_q == '0);
endmodule

// File: rtl/phs_pend_acc.sv
`timescale 1ns/1ps
module phs_pend_acc #(
  parameter int PEND_MAX = 15,
  localparam int CW = $clog2(PEND_MAX + 1) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 ret_i,
  input  logic                 take_i,
  input  logic                 take_up_i,
  output logic signed [CW-1:0] cnt_o
);
  localparam logic signed [CW:0] HI  = (CW+1)'(PEND_MAX);
  localparam logic signed [CW:0] LO  = -HI;
  localparam logic signed [CW:0] ONE = (CW+1)'(1);

  logic signed [CW-1:0] cnt_q;
  logic signed [CW:0]   sum;

  always_comb begin
    sum = {cnt_q[CW-1], cnt_q};
    if (take_i) sum = take_up_i ? sum - ONE : sum + ONE;
    // simultaneous advance and retard cancel
    if (adv_i && !ret_i)      sum = sum + ONE;
    else if (ret_i && !adv_i) sum = sum - ONE;
    if (sum > HI)      sum = HI;
    else if (sum < LO) sum = LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum[CW-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/phase_slew_ctrl.sv
`timescale 1ns/1ps
module phase_slew_ctrl
  import phs_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int MIN_GAP  = 100,
  parameter int PEND_MAX = 15,
  parameter int ACT_INIT = 128,
  parameter bit MIRROR   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ret_i,
  input  logic             ack_a_i,
  input  logic             ack_b_i,
  output logic             step_a_o,
  output logic             dir_a_o,
  output logic             step_b_o,
  output logic             dir_b_o,
  output logic             sel_o,
  output logic [POS_W-1:0] pos_a_o,
  output logic [POS_W-1:0] pos_b_o,
  output logic [POS_W-1:0] phase_o,
  output logic             overrun_o
);
  localparam int             CW         = $clog2(PEND_MAX + 1) + 1;
  localparam logic [POS_W-1:0] P_MAX    = '1;
  localparam logic [POS_W-1:0] P_INIT   = POS_W'(ACT_INIT);
  localparam logic [POS_W-1:0] P_SBY0   = MIRROR ? (P_MAX - P_INIT) : '0;

  logic [POS_W-1:0]     pos_q [2];
  step_cmd_t            cmd_q [2];
  step_cmd_t            cmd_d [2];
  logic                 sel_q, last_up_q;
  logic [1:0]           busy, ready, ack;
  logic signed [CW-1:0] pend;

  logic             act, sby, want, up, dir_now, at_lim, sby_ok, do_swap, hold;
  logic [POS_W-1:0] park;

  assign ack = {ack_b_i, ack_a_i};

  for (genvar u = 0; u < 2; u++) begin : g_unit
    phs_step_timer #(.MIN_GAP(MIN_GAP)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .issue_i (cmd_d[u].go),
      .ack_i   (ack[u]),
      .busy_o  (busy[u]),
      .ready_o (ready[u])
    );
  end

  phs_pend_acc #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv_i),
    .ret_i     (ret_i),
    .take_i    (do_swap || cmd_d[sel_q].go),
    .take_up_i (up),
    .cnt_o     (pend)
  );

  always_comb begin
    act     = sel_q;
    sby     = ~sel_q;
    want    = (pend != '0);
    up      = ~pend[CW-1];
    dir_now = want ? up : last_up_q;
    park    = dir_now ? '0 : P_MAX;
    at_lim  = up ? (pos_q[act] == P_MAX) : (pos_q[act] == '0);
    // mirror keeps the standby at the opposite end by construction
    sby_ok  = MIRROR ? 1'b1 : ((pos_q[sby] == park) && !busy[sby]);
    do_swap = want && at_lim && sby_ok;
    hold    = want && at_lim && !sby_ok;
    cmd_d[0] = '0;
    cmd_d[1] = '0;
    if (want && !at_lim && ready[act] && (!MIRROR || ready[sby])) begin
      cmd_d[act] = '{go: 1'b1, up: up};
      if (MIRROR) cmd_d[sby] = '{go: 1'b1, up: ~up};
    end
    if (!MIRROR && !do_swap && ready[sby] && (pos_q[sby] != park))
      cmd_d[sby] = '{go: 1'b1, up: (park == P_MAX)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q[0]  <= P_INIT;
      pos_q[1]  <= P_SBY0;
      cmd_q[0]  <= '0;
      cmd_q[1]  <= '0;
      sel_q     <= 1'b0;
      last_up_q <= 1'b1;
    end else begin
      for (int u = 0; u < 2; u++) begin
        cmd_q[u] <= cmd_d[u];
        if (cmd_d[u].go)
          pos_q[u] <= cmd_d[u].up ? pos_q[u] + 1'b1 : pos_q[u] - 1'b1;
      end
      if (do_swap) sel_q <= ~sel_q;
      if (want) last_up_q <= up;
    end
  end

  assign step_a_o  = cmd_q[0].go;
  assign dir_a_o   = cmd_q[0].up;
  assign step_b_o  = cmd_q[1].go;
  assign dir_b_o   = cmd_q[1].up;
  assign sel_o     = sel_q;
  assign pos_a_o   = pos_q[0];
  assign pos_b_o   = pos_q[1];
  assign phase_o   = pos_q[sel_q];
  assign overrun_o = hold;
endmodule

// File: rtl/phase_slew_ctrl_chk.sv
`timescale 1ns/1ps
module phase_slew_ctrl_chk #(
  parameter int POS_W   = 8,
  parameter int MIN_GAP = 100,
  parameter bit MIRROR  = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_a_i,
  input logic             ack_b_i,
  input logic             step_a_o,
  input logic             dir_a_o,
  input logic             step_b_o,
  input logic             dir_b_o,
  input logic             sel_o,
  input logic [POS_W-1:0] pos_a_o,
  input logic [POS_W-1:0] pos_b_o,
  input logic [POS_W-1:0] phase_o,
  input logic             overrun_o
);
  localparam int SW = $clog2(MIN_GAP + 1) + 1;
  localparam logic [POS_W-1:0] P_MAX = '1;

  logic [SW-1:0] since_a, since_b;
  logic          owe_a, owe_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_a <= SW'(MIN_GAP);
      since_b <= SW'(MIN_GAP);
      owe_a   <= 1'b0;
      owe_b   <= 1'b0;
    end else begin
      since_a <= step_a_o ? SW'(1) : ((since_a < SW'(MIN_GAP)) ? since_a + 1'b1 : since_a);
      since_b <= step_b_o ? SW'(1) : ((since_b < SW'(MIN_GAP)) ? since_b + 1'b1 : since_b);
      owe_a   <= step_a_o ? 1'b1 : (ack_a_i ? 1'b0 : owe_a);
      owe_b   <= step_b_o ? 1'b1 : (ack_b_i ? 1'b0 : owe_b);
    end
  end

  a_r8_ack_before_step_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_a_o |-> !owe_a);
  a_r8_ack_before_step_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_b_o |-> !owe_b);

  a_r9_gap_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_a_o |-> (since_a >= SW'(MIN_GAP)));
  a_r9_gap_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_b_o |-> (since_b >= SW'(MIN_GAP)));

  a_r10_pos_a_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_a_o != $past(pos_a_o)) |-> (step_a_o && (dir_a_o
      ? ({1'b0, pos_a_o} == {1'b0, $past(pos_a_o)} + 1'b1)
      : ({1'b0, pos_a_o} + 1'b1 == {1'b0, $past(pos_a_o)}))));
  a_r10_pos_b_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_b_o != $past(pos_b_o)) |-> (step_b_o && (dir_b_o
      ? ({1'b0, pos_b_o} == {1'b0, $past(pos_b_o)} + 1'b1)
      : ({1'b0, pos_b_o} + 1'b1 == {1'b0, $past(pos_b_o)}))));

  a_r4_swap_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |->
      (($past(phase_o) == P_MAX && phase_o == '0) || ($past(phase_o) == '0 && phase_o == P_MAX)));

  a_r6_hold_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> (sel_o == $past(sel_o)));

  if (MIRROR) begin : g_mirror
    a_r7_mirror_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, pos_a_o} + {1'b0, pos_b_o} == {1'b0, P_MAX}));
    a_r7_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !overrun_o);
  end
endmodule

bind phase_slew_ctrl phase_slew_ctrl_chk #(
  .POS_W(POS_W), .MIN_GAP(MIN_GAP), .MIRROR(MIRROR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_a_i(ack_a_i), .ack_b_i(ack_b_i),
  .step_a_o(step_a_o), .dir_a_o(dir_a_o), .step_b_o(step_b_o), .dir_b_o(dir_b_o),
  .sel_o(sel_o), .pos_a_o(pos_a_o), .pos_b_o(pos_b_o), .phase_o(phase_o),
  .overrun_o(overrun_o)
);

// File: tb/phase_slew_ctrl_bench.sv
`timescale 1ns/1ps
module phase_slew_ctrl_bench;
  localparam int MG = 6;

  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0, ret = 1'b0;
  always #2.5 clk = ~clk;

  logic       step_a [2], step_b [2], dir_a [2], dir_b [2], sel [2], ovr [2], ack_a [2], ack_b [2];
  logic [7:0] pa [2], pb [2], ph [2];

  phase_slew_ctrl #(.MIN_GAP(MG), .MIRROR(1'b0)) u_phase_slew_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .ret_i(ret),
    .ack_a_i(ack_a[0]), .ack_b_i(ack_b[0]),
    .step_a_o(step_a[0]), .dir_a_o(dir_a[0]), .step_b_o(step_b[0]), .dir_b_o(dir_b[0]),
    .sel_o(sel[0]), .pos_a_o(pa[0]), .pos_b_o(pb[0]), .phase_o(ph[0]), .overrun_o(ovr[0]));

  phase_slew_ctrl #(.MIN_GAP(MG), .MIRROR(1'b1)) u_phase_slew_ctrl_mir (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .ret_i(ret),
    .ack_a_i(ack_a[1]), .ack_b_i(ack_b[1]),
    .step_a_o(step_a[1]), .dir_a_o(dir_a[1]), .step_b_o(step_b[1]), .dir_b_o(dir_b[1]),
    .sel_o(sel[1]), .pos_a_o(pa[1]), .pos_b_o(pb[1]), .phase_o(ph[1]), .overrun_o(ovr[1]));

  // acknowledging unit stubs: A answers after 2 cycles, B after 3
  logic [1:0] sra [2];
  logic [2:0] srb [2];
  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        sra[k] <= '0;
        srb[k] <= '0;
      end else begin
        sra[k] <= {sra[k][0], step_a[k]};
        srb[k] <= {srb[k][1:0], step_b[k]};
      end
    end
  end
  assign ack_a[0] = sra[0][1];
  assign ack_a[1] = sra[1][1];
  assign ack_b[0] = srb[0][2];
  assign ack_b[1] = srb[1][2];

  int nchk = 0, nfail = 0;
  bit run = 1'b0, done = 1'b0;
  int acc [2], tgt [2], sa [2], sb [2];
  bit owa [2], owb [2], ovr_seen [2], povr [2], psel [2];
  logic [7:0] pph [2], ppa [2], ppb [2];
  int req_seen = 0;

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
    end
  endtask

  // behavioural model, compared every clock
  always @(negedge clk) begin
    if (run) begin
      int r;
      r = req_seen;
      req_seen = (adv && !ret) ? 1 : ((ret && !adv) ? -1 : 0);
      for (int k = 0; k < 2; k++) begin
        int d, op, nv;
        logic signed [7:0] dd;
        dd = ph[k] - pph[k];
        d  = int'(dd);
        op = tgt[k] - acc[k];
        chk(d >= -1 && d <= 1, "R2 phase moves at most one step", d, sgn(op));
        if (d != 0) chk(d == sgn(op), "R2 step follows pending direction", d, sgn(op));
        if (sel[k] != psel[k]) begin
          chk((d == 1 && pph[k] == 8'd255) || (d == -1 && pph[k] == 8'd0),
              "R4 select toggles only at limit", int'(pph[k]), (d == 1) ? 255 : 0);
          chk(!povr[k], "R6 select toggled after overrun", 1, 0);
        end
        acc[k] += d;
        nv = op + r - d;
        if (nv > 15) nv = 15;
        if (nv < -15) nv = -15;
        tgt[k] = acc[k] + nv;
        if (pa[k] != ppa[k])
          chk(step_a[k] && (dir_a[k] ? int'(pa[k]) == int'(ppa[k]) + 1 : int'(pa[k]) + 1 == int'(ppa[k])),
              "R10 unit A position change", int'(pa[k]), int'(ppa[k]));
        if (pb[k] != ppb[k])
          chk(step_b[k] && (dir_b[k] ? int'(pb[k]) == int'(ppb[k]) + 1 : int'(pb[k]) + 1 == int'(ppb[k])),
              "R10 unit B position change", int'(pb[k]), int'(ppb[k]));
        if (step_a[k]) chk(pa[k] != ppa[k], "R10 unit A step without move", int'(pa[k]), int'(ppa[k]));
        if (step_b[k]) chk(pb[k] != ppb[k], "R10 unit B step without move", int'(pb[k]), int'(ppb[k]));
        if (step_a[k]) chk(!owa[k], "R8 unit A stepped before ack", 1, 0);
        if (step_b[k]) chk(!owb[k], "R8 unit B stepped before ack", 1, 0);
        if (ack_a[k]) owa[k] = 1'b0;
        if (ack_b[k]) owb[k] = 1'b0;
        if (step_a[k]) owa[k] = 1'b1;
        if (step_b[k]) owb[k] = 1'b1;
        if (step_a[k]) begin chk(sa[k] >= MG, "R9 unit A step spacing", sa[k], MG); sa[k] = 1; end
        else sa[k]++;
        if (step_b[k]) begin chk(sb[k] >= MG, "R9 unit B step spacing", sb[k], MG); sb[k] = 1; end
        else sb[k]++;
        if (k == 1) begin
          chk(int'(pa[1]) + int'(pb[1]) == 255, "R7 mirror positions sum", int'(pa[1]) + int'(pb[1]), 255);
          chk(!ovr[1], "R7 mirror never overruns", 1, 0);
        end
        if (ovr[k]) ovr_seen[k] = 1'b1;
        povr[k] = ovr[k];
        psel[k] = sel[k];
        pph[k]  = ph[k];
        ppa[k]  = pa[k];
        ppb[k]  = pb[k];
      end
    end
  end

  task automatic push(input bit up);
    @(posedge clk);
    while (iabs(tgt[0] - acc[0]) > 12 || iabs(tgt[1] - acc[1]) > 12) @(posedge clk);
    #1;
    adv = up;
    ret = !up;
    @(posedge clk);
    #1;
    adv = 1'b0;
    ret = 1'b0;
  endtask

  task automatic drain;
    int n;
    n = 0;
    while ((tgt[0] != acc[0] || tgt[1] != acc[1]) && n < 20000) begin
      @(posedge clk);
      n++;
    end
    chk(n < 20000, "R2 pending steps drained", n, 0);
    repeat (20) @(posedge clk);
  endtask

  task automatic check_park(input int expected, input string tag);
    @(negedge clk);
    chk(int'(sel[0] ? pa[0] : pb[0]) == expected, tag, int'(sel[0] ? pa[0] : pb[0]), expected);
  endtask

  initial begin
    int base [2];
    for (int k = 0; k < 2; k++) begin
      acc[k] = 0; tgt[k] = 0; sa[k] = MG; sb[k] = MG;
      owa[k] = 0; owb[k] = 0; ovr_seen[k] = 0; povr[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      chk(pa[k] == 8'd128, "R1 unit A reset position", int'(pa[k]), 128);
      chk(pb[k] == ((k == 1) ? 8'd127 : 8'd0), "R1 unit B reset position", int'(pb[k]), (k == 1) ? 127 : 0);
      chk(!sel[k] && !step_a[k] && !step_b[k] && !ovr[k], "R1 outputs idle after reset",
          int'({sel[k], step_a[k], step_b[k], ovr[k]}), 0);
      chk(ph[k] == 8'd128, "R1 selected phase after reset", int'(ph[k]), 128);
    end
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      psel[k] = sel[k]; pph[k] = ph[k]; ppa[k] = pa[k]; ppb[k] = pb[k];
    end
    rst_n = 1'b1;
    run   = 1'b1;

    // R2 simultaneous advance and retard are ignored
    @(posedge clk); #1; adv = 1'b1; ret = 1'b1;
    repeat (5) @(posedge clk);
    #1; adv = 1'b0; ret = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(ph[k] == 8'd128 && acc[k] == 0, "R2 both requests together ignored", int'(ph[k]), 128);

    // retard from reset: unit B must climb to 255, forcing a held hand-off
    for (int i = 0; i < 200; i++) push(1'b0);
    drain();
    for (int k = 0; k < 2; k++) chk(acc[k] == -200, "R2 200 retards", acc[k], -200);
    chk(ovr_seen[0], "R6 overrun raised while standby repositions", 0, 1);
    chk(!ovr_seen[1], "R7 no overrun in mirror mode", 1, 0);
    repeat (2000) @(posedge clk);
    check_park(255, "R5 standby parked high after retard");

    // 1000 advances, reversal retargets the standby
    for (int k = 0; k < 2; k++) base[k] = acc[k];
    for (int i = 0; i < 1000; i++) push(1'b1);
    drain();
    for (int k = 0; k < 2; k++) chk(acc[k] - base[k] == 1000, "R2 1000 advances", acc[k] - base[k], 1000);
    repeat (2000) @(posedge clk);
    check_park(0, "R5 standby parked low after advance");

    // 1000 retards
    for (int k = 0; k < 2; k++) base[k] = acc[k];
    for (int i = 0; i < 1000; i++) push(1'b0);
    drain();
    for (int k = 0; k < 2; k++) chk(base[k] - acc[k] == 1000, "R2 1000 retards", base[k] - acc[k], 1000);
    repeat (2000) @(posedge clk);
    check_park(255, "R5 standby parked high after second retard");

    // R3 held burst saturates the pending count
    for (int k = 0; k < 2; k++) base[k] = acc[k];
    @(posedge clk); #1; adv = 1'b1;
    repeat (40) @(posedge clk);
    #1; adv = 1'b0;
    drain();
    for (int k = 0; k < 2; k++) begin
      chk(acc[k] - base[k] >= 15 && acc[k] - base[k] < 40, "R3 burst limited by saturation", acc[k] - base[k], 22);
      chk(acc[k] == tgt[k], "R3 model and phase agree after burst", acc[k], tgt[k]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R2 run did not complete actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule